// File: doc/BRIEF.md
# Status Register Transfer Unit

This block holds a processor's current status word and a bank of saved status words, one for each exception mode. It carries out the two instructions that move status words. A read copies the current word or the saved word into a general register. A write loads a status word from a general-register operand or from a rotated 8-bit immediate. A write replaces either the whole word or only the four condition flags. The mode field of the current word decides how much of the current word a full write may change, and which saved copy is visible.

Each request lasts one cycle and is qualified by `req_valid`. Read data is combinational, so it shows the contents from before any update in that cycle. A write lands on the next rising clock edge. A request that names register 15, or that pairs an immediate with a full write, is flagged illegal and leaves all state untouched. Instruction fetch, condition evaluation and exception entry belong to the surrounding pipeline.

Top module: `psr_xfer_unit`

## Requirements
- R1: Once reset is released, the current status word is 0x000000D3: mode supervisor, both interrupt masks set, all flags clear. Every saved word is zero and `rd_data` is zero.
- R2: A legal read (`req_write`=0) returns all 32 bits of the selected word on `rd_data` in the same cycle. `req_saved`=1 selects the current mode's saved word and 0 selects the current word. When there is no legal read, `rd_data` is zero.
- R3: Bits 31,30,29,28 hold the N, Z, C and V flags. A legal write with `req_flags_only`=1 replaces bits 31:28 of the target with operand bits 31:28 and keeps bits 27:0, in every mode.
- R4: In user mode (mode field bits 4:0 = 10000), a full write to the current word changes only bits 31:28.
- R5: In any mode other than user, a legal full write to the current word replaces all 32 bits, including the mode field.
- R6: Saved-word reads and writes use the copy of the current mode: fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011. `cur_saved_psr` always shows that copy.
- R7: In user and system (11111) modes there is no saved word. A saved read returns zero, a saved write changes nothing, and `cur_saved_psr` is zero.
- R8: When `req_use_imm`=1, the operand is `req_imm_val` zero-extended to 32 bits and rotated right by 2×`req_imm_rot`. An immediate used with `req_flags_only`=0 makes the request illegal.
- R9: A read with `req_rd_num`=15, or a register-operand write with `req_rm_num`=15, raises `req_illegal` in the same cycle. It changes no state and returns zero on `rd_data`.
- R10: A write becomes visible after the next rising edge. Without `req_valid`, no stored word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write status word, 0 = read status word |
| req_saved | input | 1 | 1 = saved word of current mode, 0 = current word |
| req_flags_only | input | 1 | Write touches bits 31:28 only |
| req_use_imm | input | 1 | Write operand comes from the rotated immediate |
| req_rd_num | input | 4 | Destination register number of a read |
| req_rm_num | input | 4 | Source register number of a write |
| req_rm_data | input | 32 | Source register contents |
| req_imm_val | input | 8 | Immediate byte |
| req_imm_rot | input | 4 | Immediate rotate field (rotate right by twice this value) |
| rd_data | output | 32 | Read result for the destination register |
| req_illegal | output | 1 | Current request is illegal and is ignored |
| cur_psr | output | 32 | Current status word |
| cur_saved_psr | output | 32 | Saved word of the current mode, zero if none |

## Verification
A wrong write mask shows on `cur_psr` one edge after the offending write, as bits 27:0 that changed or failed to change. A bad bank decode first shows on `cur_saved_psr` in the cycle the mode field changes, since a different copy, or zero, appears in place of the expected one. A corrupted saved copy may stay hidden until the unit returns to its mode, so the stimulus keeps cycling through all modes and compares every visible word after every edge.

// File: rtl/psr_xfer_pkg.sv
package psr_xfer_pkg;

  localparam int unsigned PSR_W       = 32;
  localparam int unsigned FLAG_W      = 4;
  localparam int unsigned MODE_W      = 5;
  localparam int unsigned NUM_SAVED   = 5;
  localparam int unsigned SAVED_IDX_W = $clog2(NUM_SAVED);

  typedef logic [MODE_W-1:0] mode_t;

  // mode field encodings (decoded by neighbouring logic, so fixed)
  localparam mode_t MODE_USR = 5'b10000;
  localparam mode_t MODE_FIQ = 5'b10001;
  localparam mode_t MODE_IRQ = 5'b10010;
  localparam mode_t MODE_SVC = 5'b10011;
  localparam mode_t MODE_ABT = 5'b10111;
  localparam mode_t MODE_UND = 5'b11011;
  localparam mode_t MODE_SYS = 5'b11111;

  typedef struct packed {
    logic                   present;
    logic [SAVED_IDX_W-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t saved_slot(input mode_t m);
    bank_sel_t s;
    s.present = 1'b1;
    s.idx     = '0;
    unique case (m)
      MODE_FIQ: s.idx = SAVED_IDX_W'(0);
      MODE_IRQ: s.idx = SAVED_IDX_W'(1);
      MODE_SVC: s.idx = SAVED_IDX_W'(2);
      MODE_ABT: s.idx = SAVED_IDX_W'(3);
      MODE_UND: s.idx = SAVED_IDX_W'(4);
      default:  s.present = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/psr_imm_expand.sv
module psr_imm_expand #(
  parameter int unsigned OUT_W = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm_val,
  input  logic [ROT_W-1:0] imm_rot,
  output logic [OUT_W-1:0] operand
);

  localparam int unsigned SH_W = ROT_W + 1;

  logic [2*OUT_W-1:0] doubled;
  logic [SH_W-1:0]    shift_amt;

  always_comb begin
    shift_amt = {imm_rot, 1'b0};
    doubled   = {2{OUT_W'(imm_val)}} >> shift_amt;
    operand   = doubled[OUT_W-1:0];
  end

endmodule

// File: rtl/psr_write_ctrl.sv
module psr_write_ctrl
  import psr_xfer_pkg::*;
#(
  parameter int unsigned REG_NUM_W = 4,
  parameter int unsigned PC_REG    = 15
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_saved,
  input  logic                 req_flags_only,
  input  logic                 req_use_imm,
  input  logic [REG_NUM_W-1:0] req_rd_num,
  input  logic [REG_NUM_W-1:0] req_rm_num,
  input  logic [PSR_W-1:0]     req_rm_data,
  input  logic [PSR_W-1:0]     imm_operand,
  input  mode_t                cur_mode,
  input  logic                 saved_present,
  output logic                 illegal,
  output logic                 do_read,
  output logic                 cur_we,
  output logic                 saved_we,
  output logic [PSR_W-1:0]     wr_mask,
  output logic [PSR_W-1:0]     wr_operand
);

  localparam logic [PSR_W-1:0] FLAG_MASK = {{FLAG_W{1'b1}}, {(PSR_W-FLAG_W){1'b0}}};
  localparam logic [REG_NUM_W-1:0] PC_NUM = REG_NUM_W'(PC_REG);

  logic bad_src;
  logic bad_dst;
  logic legal;
  logic flags_limited;

  always_comb begin
    bad_src = req_use_imm ? !req_flags_only : (req_rm_num == PC_NUM);
    bad_dst = (req_rd_num == PC_NUM);
    illegal = req_valid && (req_write ? bad_src : bad_dst);
    legal   = req_valid && !illegal;

    do_read  = legal && !req_write;
    cur_we   = legal && req_write && !req_saved;
    saved_we = legal && req_write && req_saved && saved_present;

    flags_limited = req_flags_only || (!req_saved && (cur_mode == MODE_USR));
    wr_mask       = flags_limited ? FLAG_MASK : '1;
    wr_operand    = req_use_imm ? imm_operand : req_rm_data;
  end

endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_xfer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SAVED_IDX_W-1:0] idx,
  input  logic                   present,
  input  logic [PSR_W-1:0]       mask,
  input  logic [PSR_W-1:0]       operand,
  output logic [PSR_W-1:0]       rd_val
);

  logic [PSR_W-1:0]     slot_q [NUM_SAVED];
  logic [PSR_W-1:0]     slot_d [NUM_SAVED];
  logic [NUM_SAVED-1:0] slot_we;

  for (genvar g = 0; g < NUM_SAVED; g++) begin : g_slot
    always_comb begin
      slot_we[g] = we && (idx == SAVED_IDX_W'(g));
      slot_d[g]  = (slot_q[g] & ~mask) | (operand & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_we[g]) begin
        slot_q[g] <= slot_d[g];
      end
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[g] |=> $stable(slot_q[g])) else $error("slot changed without enable"); // R6
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_SAVED; i++) begin
      if (present && (idx == SAVED_IDX_W'(i))) rd_val = slot_q[i];
    end
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)) else $error("several saved slots written"); // R6

endmodule

// File: rtl/psr_xfer_unit.sv
module psr_xfer_unit
  import psr_xfer_pkg::*;
#(
  parameter int unsigned REG_NUM_W = 4,
  parameter int unsigned PC_REG    = 15,
  parameter int unsigned IMM_W     = 8,
  parameter int unsigned ROT_W     = 4,
  parameter logic [31:0] RESET_PSR = 32'h0000_00D3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_saved,
  input  logic                 req_flags_only,
  input  logic                 req_use_imm,
  input  logic [REG_NUM_W-1:0] req_rd_num,
  input  logic [REG_NUM_W-1:0] req_rm_num,
  input  logic [31:0]          req_rm_data,
  input  logic [IMM_W-1:0]     req_imm_val,
  input  logic [ROT_W-1:0]     req_imm_rot,
  output logic [31:0]          rd_data,
  output logic                 req_illegal,
  output logic [31:0]          cur_psr,
  output logic [31:0]          cur_saved_psr
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // current status word
  logic [PSR_W-1:0] cpsr_q;
  logic [PSR_W-1:0] cpsr_d;
  logic             cpsr_en;
  mode_t            cur_mode;
  bank_sel_t        bank_sel;

  logic [PSR_W-1:0] imm_operand;
  logic             do_read;
  logic             cur_we;
  logic             saved_we;
  logic [PSR_W-1:0] wr_mask;
  logic [PSR_W-1:0] wr_operand;
  logic [PSR_W-1:0] saved_val;

  always_comb begin
    cur_mode = cpsr_q[MODE_W-1:0];
    bank_sel = saved_slot(cur_mode);
  end

  psr_imm_expand #(
    .OUT_W (PSR_W),
    .IMM_W (IMM_W),
    .ROT_W (ROT_W)
  ) i_imm_expand (
    .imm_val (req_imm_val),
    .imm_rot (req_imm_rot),
    .operand (imm_operand)
  );

  psr_write_ctrl #(
    .REG_NUM_W (REG_NUM_W),
    .PC_REG    (PC_REG)
  ) i_write_ctrl (
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_saved      (req_saved),
    .req_flags_only (req_flags_only),
    .req_use_imm    (req_use_imm),
    .req_rd_num     (req_rd_num),
    .req_rm_num     (req_rm_num),
    .req_rm_data    (req_rm_data),
    .imm_operand    (imm_operand),
    .cur_mode       (cur_mode),
    .saved_present  (bank_sel.present),
    .illegal        (req_illegal),
    .do_read        (do_read),
    .cur_we         (cur_we),
    .saved_we       (saved_we),
    .wr_mask        (wr_mask),
    .wr_operand     (wr_operand)
  );

  psr_saved_bank i_saved_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (saved_we),
    .idx     (bank_sel.idx),
    .present (bank_sel.present),
    .mask    (wr_mask),
    .operand (wr_operand),
    .rd_val  (saved_val)
  );

  // next state of the current word
  always_comb begin
    cpsr_en = cur_we;
    cpsr_d  = (cpsr_q & ~wr_mask) | (wr_operand & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cpsr_q <= RESET_PSR;
    end else if (cpsr_en) begin
      cpsr_q <= cpsr_d;
    end
  end

  always_comb begin
    cur_psr       = cpsr_q;
    cur_saved_psr = saved_val;
    rd_data       = '0;
    if (do_read) rd_data = req_saved ? saved_val : cpsr_q;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> $stable(cur_psr)) else $error("state moved without request"); // R10

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_illegal) |=> ($stable(cur_psr) && $stable(cur_saved_psr)))
    else $error("illegal request changed state"); // R9

  AST_PC_READ_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_write && req_rd_num == REG_NUM_W'(PC_REG)) |-> (req_illegal && rd_data == '0))
    else $error("read to register 15 accepted"); // R9

  AST_FLAGS_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_illegal && req_write && req_flags_only) |=>
      (cur_psr[PSR_W-FLAG_W-1:0] == $past(cur_psr[PSR_W-FLAG_W-1:0])))
    else $error("flags-only write touched low bits"); // R3

  AST_USER_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !req_saved && cur_psr[MODE_W-1:0] == MODE_USR) |=>
      $stable(cur_psr[PSR_W-FLAG_W-1:0]))
    else $error("user write changed control bits"); // R4

  AST_PRIV_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_illegal && req_write && !req_saved && !req_flags_only &&
     cur_psr[MODE_W-1:0] != MODE_USR) |=> (cur_psr == $past(req_rm_data)))
    else $error("privileged full write incomplete"); // R5

  AST_NO_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_psr[MODE_W-1:0] == MODE_USR || cur_psr[MODE_W-1:0] == MODE_SYS) |->
      (cur_saved_psr == '0)) else $error("saved word visible without bank"); // R7

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(req_valid && !req_write) |-> (rd_data == '0)) else $error("read data without read"); // R2

  AST_IMM_BITCOUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_use_imm) |-> ($countones(imm_operand) == $countones(req_imm_val)))
    else $error("immediate rotation lost bits"); // R8

endmodule

// File: tb/test_psr_xfer_unit.sv
`timescale 1ns/1ps
module test_psr_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_saved, req_flags_only, req_use_imm;
  logic [3:0]  req_rd_num, req_rm_num, req_imm_rot;
  logic [31:0] req_rm_data;
  logic [7:0]  req_imm_val;
  logic [31:0] rd_data, cur_psr, cur_saved_psr;
  logic        req_illegal;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_cpsr;
  logic [31:0] m_saved [5];

  always #10 clk = ~clk;

  psr_xfer_unit i_psr_xfer_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_saved(req_saved), .req_flags_only(req_flags_only), .req_use_imm(req_use_imm),
    .req_rd_num(req_rd_num), .req_rm_num(req_rm_num), .req_rm_data(req_rm_data),
    .req_imm_val(req_imm_val), .req_imm_rot(req_imm_rot), .rd_data(rd_data),
    .req_illegal(req_illegal), .cur_psr(cur_psr), .cur_saved_psr(cur_saved_psr)
  );

  function automatic int bank_of(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] rotr_imm(logic [7:0] v, logic [3:0] r);
    int s;
    logic [31:0] x;
    s = 2 * int'(r);
    x = {24'h0, v};
    if (s == 0) return x;
    return (x >> s) | (x << (32 - s));
  endfunction

  function automatic logic [31:0] exp_saved();
    int b;
    b = bank_of(m_cpsr[4:0]);
    return (b < 0) ? 32'h0 : m_saved[b];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check(req, cur_psr, m_cpsr);
    check(req, cur_saved_psr, exp_saved());
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cpsr = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_saved[i] = '0;
  endtask

  // one request: drive at negedge, check combinational results, update model after edge
  task automatic run_op(bit wr, bit sv, bit fo, bit ui, logic [3:0] rd, logic [3:0] rm,
                        logic [31:0] data, logic [7:0] iv, logic [3:0] ir, string req);
    bit          ill;
    logic [31:0] exp_rd, op, mask;
    int          b;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_saved = sv; req_flags_only = fo;
    req_use_imm = ui; req_rd_num = rd; req_rm_num = rm; req_rm_data = data;
    req_imm_val = iv; req_imm_rot = ir;
    #2;
    ill    = wr ? (ui ? !fo : (rm == 4'd15)) : (rd == 4'd15);
    exp_rd = 32'h0;
    if (!wr && !ill) exp_rd = sv ? exp_saved() : m_cpsr;
    check({req, " illegal"}, {31'h0, req_illegal}, {31'h0, ill});
    check({req, " rd_data"}, rd_data, exp_rd);
    // state must still be the old one before the edge
    check({req, " R10 pre-edge"}, cur_psr, m_cpsr);
    if (wr && !ill) begin
      op = ui ? rotr_imm(iv, ir) : data;
      if (!sv) begin
        mask = (fo || m_cpsr[4:0] == 5'b10000) ? 32'hF000_0000 : 32'hFFFF_FFFF;
        m_cpsr = (m_cpsr & ~mask) | (op & mask);
      end else begin
        b = bank_of(m_cpsr[4:0]);
        mask = fo ? 32'hF000_0000 : 32'hFFFF_FFFF;
        if (b >= 0) m_saved[b] = (m_saved[b] & ~mask) | (op & mask);
      end
    end
    @(posedge clk);
    #3;
    check_state({req, " post-edge"});
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    req_rm_data = 32'hFFFF_FFFF;
    repeat (n) @(negedge clk);
    check_state("R10 idle");
  endtask

  logic [4:0] mode_list [7];
  bit         done = 1'b0;

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    mode_list = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_saved = 1'b0;
    req_flags_only = 1'b0; req_use_imm = 1'b0; req_rd_num = '0; req_rm_num = '0;
    req_rm_data = '0; req_imm_val = '0; req_imm_rot = '0;

    do_reset();
    // R1 reset state
    check("R1 cur_psr", cur_psr, 32'h0000_00D3);
    check("R1 saved", cur_saved_psr, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);

    // R2 read current word in supervisor mode
    run_op(0, 0, 0, 0, 4'd3, 4'd0, 32'h0, 8'h0, 4'h0, "R2 read cur");
    // R8 R3 flags-only immediate: 0x0A ror 4 -> 0xA0000000
    run_op(1, 0, 1, 1, 4'd0, 4'd15, 32'h0, 8'h0A, 4'h2, "R8 R3 imm flags");
    check("R3 flags NZCV=1010", cur_psr, 32'hA000_00D3);
    // R8 immediate with full write is illegal
    run_op(1, 0, 0, 1, 4'd0, 4'd1, 32'h0, 8'hFF, 4'h0, "R8 imm full illegal");
    // R6 saved supervisor copy
    run_op(1, 1, 0, 0, 4'd0, 4'd2, 32'h1234_5678, 8'h0, 4'h0, "R6 write svc saved");
    run_op(0, 1, 0, 0, 4'd4, 4'd0, 32'h0, 8'h0, 4'h0, "R6 read svc saved");
    // R3 flags-only write to saved word
    run_op(1, 1, 1, 0, 4'd0, 4'd2, 32'h5FFF_FFFF, 8'h0, 4'h0, "R3 saved flags");
    check("R3 saved flags value", cur_saved_psr, 32'h5234_5678);
    // R5 privileged full write switches to interrupt mode
    run_op(1, 0, 0, 0, 4'd0, 4'd5, 32'h0000_00D2, 8'h0, 4'h0, "R5 to irq");
    check("R6 irq copy empty", cur_saved_psr, 32'h0);
    run_op(1, 1, 0, 0, 4'd0, 4'd5, 32'hCAFE_0011, 8'h0, 4'h0, "R6 write irq saved");
    run_op(1, 0, 0, 0, 4'd0, 4'd5, 32'h0000_00D3, 8'h0, 4'h0, "R5 back to svc");
    check("R6 svc copy kept", cur_saved_psr, 32'h5234_5678);
    // R9 register 15
    run_op(1, 0, 0, 0, 4'd0, 4'd15, 32'hFFFF_FFFF, 8'h0, 4'h0, "R9 rm15");
    run_op(0, 0, 0, 0, 4'd15, 4'd0, 32'h0, 8'h0, 4'h0, "R9 rd15");
    // R7 system mode
    run_op(1, 0, 0, 0, 4'd0, 4'd1, 32'h0000_001F, 8'h0, 4'h0, "R5 to sys");
    run_op(1, 1, 0, 0, 4'd0, 4'd1, 32'hFFFF_FFFF, 8'h0, 4'h0, "R7 sys saved write");
    run_op(0, 1, 0, 0, 4'd2, 4'd0, 32'h0, 8'h0, 4'h0, "R7 sys saved read");
    // R4 user mode
    run_op(1, 0, 0, 0, 4'd0, 4'd1, 32'h0000_0010, 8'h0, 4'h0, "R5 to usr");
    run_op(1, 0, 0, 0, 4'd0, 4'd1, 32'hFFFF_FFFF, 8'h0, 4'h0, "R4 usr full");
    check("R4 usr only flags", cur_psr, 32'hF000_0010);
    run_op(0, 1, 0, 0, 4'd2, 4'd0, 32'h0, 8'h0, 4'h0, "R7 usr saved read");
    idle(4);

    // random phase, fixed seed
    do_reset();
    begin
      int user_ops = 0;
      void'($urandom(32'd20240611));
      for (int k = 0; k < 3000; k++) begin
        bit wr, sv, fo, ui;
        logic [31:0] d;
        wr = ($urandom % 3) != 0;
        sv = ($urandom % 2) != 0;
        fo = ($urandom % 2) != 0;
        ui = ($urandom % 4) == 0;
        d  = $urandom;
        if (wr && !sv && !fo) d[4:0] = mode_list[$urandom % 7];
        if ($urandom % 20 == 0) begin
          idle(1 + $urandom % 3);
        end
        run_op(wr, sv, fo, ui, 4'($urandom), 4'($urandom), d, 8'($urandom), 4'($urandom),
               "R2 R3 R4 R5 R6 R7 R8 R9 random");
        if (m_cpsr[4:0] == 5'b10000) user_ops++;
        if (user_ops > 20) begin
          user_ops = 0;
          do_reset();
          check("R1 re-reset", cur_psr, 32'h0000_00D3);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule